// File: doc/BRIEF.md
# Intra-Vector Reduction Unit

This block turns one 256-bit operand vector into a single scalar. The vector holds sixteen signed 16-bit lanes, and the unit combines those lanes with each other rather than pairing them with the lanes of a second vector. It supports three reductions. The first adds all lanes of operand A. The second multiplies each lane of A by the matching lane of B and adds the sixteen products. The third finds the smallest lane of A and reports which lane it sits in.

Each lane first passes through a front end, which either sign-extends the lane or forms its product with B. A balanced binary tree with four levels then reduces the sixteen values. Every node of the tree carries a running sum and a running minimum with that minimum's lane number. A register stage sits in front of the tree and after every second tree level. The unit takes a new operation in every cycle and returns each result a fixed number of cycles later, with a valid strobe that travels alongside the data.

Top module: `vred_unit`

## Requirements
- R1: With `in_op` = 0 (sum), `out_result` is the exact signed sum of the sixteen lanes of `in_a`, sign-extended to 36 bits. Lane i occupies bits 16i+15 down to 16i.
- R2: With `in_op` = 1 (dot product), `out_result` is the exact signed sum of the sixteen products of lane i of `in_a` and lane i of `in_b`, with no overflow in 36 bits.
- R3: With `in_op` = 2 (minimum), `out_result` is the smallest signed lane of `in_a`, sign-extended to 36 bits, and `out_idx` is the number of the lane that holds it.
- R4: When several lanes share the minimum value, `out_idx` reports the lowest of their lane numbers.
- R5: For the sum, dot-product and code-3 operations, `out_idx` is 0.
- R6: A request accepted with `in_valid` high at a rising edge appears on the outputs, with `out_valid` high, after exactly three rising edges. Requests on consecutive cycles give results on consecutive cycles.
- R7: `in_op` = 3 behaves exactly like the sum operation.
- R8: While `rst_n` is low and afterwards, `out_valid` stays low until a request has been accepted. Cycles with `in_valid` low produce no `out_valid` pulse.
- R9: For the sum and minimum operations the value of `in_b` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation: 0 sum, 1 dot product, 2 minimum, 3 sum |
| in_a | input | 256 | Operand vector A, sixteen signed lanes |
| in_b | input | 256 | Operand vector B, used only by the dot product |
| out_valid | output | 1 | Result strobe |
| out_result | output | 36 | Signed scalar result |
| out_idx | output | 4 | Lane number of the minimum, 0 for other operations |

## Verification
The hardest case to produce is a minimum shared by several lanes. Uniform 16-bit random lanes almost never repeat the smallest value, so the tie-break rule would go unexercised. To reach it, the stimulus often draws lanes from a range of only four values, which makes equal minima in separate subtrees common. Directed vectors add further cases: all lanes equal, a lone minimum in the last lane, and the full-scale extremes that push the sum and the dot product to the edges of their widths.

// File: rtl/vred_pkg.sv
package vred_pkg;

   // Operation codes seen on in_op; code 3 is an alias of the plain sum.
   typedef enum logic [1:0] {
      VR_SUM     = 2'd0,
      VR_DOT     = 2'd1,
      VR_MIN     = 2'd2,
      VR_SUM_ALT = 2'd3
   } vred_op_e;

   // Register stages of the tree: one at its input, one after every
   // levels_per_reg levels, and always one after the last level.
   function automatic int reg_stages(input int levels, input int levels_per_reg);
      int n;
      n = 0;
      for (int l = 0; l <= levels; l++) begin
         if (l == 0 || (l % levels_per_reg) == 0 || l == levels) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/vred_front.sv
// Per-lane front end: each lane becomes a tree leaf carrying
// {sum operand, minimum candidate, lane number}.
module vred_front #(
   parameter int LANES = 16,
   parameter int LW    = 16,
   parameter int SW    = 36,
   parameter int IW    = 4
) (
   input  logic                        dot_sel,
   input  logic [LANES*LW-1:0]         vec_a,
   input  logic [LANES*LW-1:0]         vec_b,
   output logic [LANES*(SW+LW+IW)-1:0] leaves
);
   localparam int NW = SW + LW + IW;
   localparam int PW = 2 * LW;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic signed [LW-1:0] av;
      logic signed [LW-1:0] bv;
      logic signed [PW-1:0] prod;
      logic        [SW-1:0] term;

      assign av   = vec_a[i*LW +: LW];
      assign bv   = vec_b[i*LW +: LW];
      assign prod = av * bv;

      always_comb begin
         if (dot_sel) term = {{(SW-PW){prod[PW-1]}}, prod};
         else         term = {{(SW-LW){av[LW-1]}}, av};
      end

      assign leaves[i*NW +: NW] = {term, av, IW'(i)};
   end

endmodule

// File: rtl/vred_node.sv
// One tree node: adds the two sums and keeps the smaller minimum.
// The lower-lane child wins on equal values.
module vred_node #(
   parameter int SW = 36,
   parameter int LW = 16,
   parameter int IW = 4
) (
   input  logic [SW+LW+IW-1:0] lo,
   input  logic [SW+LW+IW-1:0] hi,
   output logic [SW+LW+IW-1:0] y
);
   localparam int NW = SW + LW + IW;

   logic [SW-1:0]        sum_lo, sum_hi;
   logic signed [LW-1:0] min_lo, min_hi;
   logic [IW-1:0]        idx_lo, idx_hi;
   logic                 take_hi;

   assign sum_lo = lo[NW-1 -: SW];
   assign sum_hi = hi[NW-1 -: SW];
   assign min_lo = lo[IW +: LW];
   assign min_hi = hi[IW +: LW];
   assign idx_lo = lo[IW-1:0];
   assign idx_hi = hi[IW-1:0];

   assign take_hi = min_hi < min_lo;

   assign y = {sum_lo + sum_hi,
               take_hi ? min_hi : min_lo,
               take_hi ? idx_hi : idx_lo};

endmodule

// File: rtl/vred_tree.sv
// Balanced reduction tree with configurable register spacing.
module vred_tree #(
   parameter int LANES = 16,
   parameter int LW    = 16,
   parameter int SW    = 36,
   parameter int IW    = 4,
   parameter int LPS   = 2
) (
   input  logic                        clk,
   input  logic [LANES*(SW+LW+IW)-1:0] leaves,
   output logic [SW+LW+IW-1:0]         root
);
   localparam int NW  = SW + LW + IW;
   localparam int LOG = $clog2(LANES);
   localparam int BW  = LANES * NW;

   logic [BW-1:0] raw [0:LOG];
   logic [BW-1:0] stg [0:LOG];

   assign raw[0] = leaves;

   for (genvar l = 0; l <= LOG; l++) begin : g_lvl
      if (l == 0 || (l % LPS) == 0 || l == LOG) begin : g_reg
         always_ff @(posedge clk) stg[l] <= raw[l];
      end else begin : g_thru
         assign stg[l] = raw[l];
      end

      if (l < LOG) begin : g_comb
         localparam int NOUT = LANES >> (l + 1);
         for (genvar n = 0; n < NOUT; n++) begin : g_node
            vred_node #(.SW(SW), .LW(LW), .IW(IW)) u_node (
               .lo (stg[l][(2*n)*NW   +: NW]),
               .hi (stg[l][(2*n+1)*NW +: NW]),
               .y  (raw[l+1][n*NW +: NW])
            );
         end
         assign raw[l+1][BW-1:NOUT*NW] = '0;
      end
   end

   assign root = stg[LOG][NW-1:0];

endmodule

// File: rtl/vred_unit.sv
module vred_unit #(
   parameter int LANES = 16,
   parameter int LW    = 16,
   parameter int LPS   = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 in_valid,
   input  logic [1:0]                           in_op,
   input  logic [LANES*LW-1:0]                  in_a,
   input  logic [LANES*LW-1:0]                  in_b,
   output logic                                 out_valid,
   output logic [2*LW+$clog2(LANES)-1:0]        out_result,
   output logic [$clog2(LANES)-1:0]             out_idx
);
   import vred_pkg::*;

   localparam int LOG  = $clog2(LANES);
   localparam int IW   = LOG;
   localparam int SW   = 2 * LW + LOG;
   localparam int NW   = SW + LW + IW;
   localparam int NREG = reg_stages(LOG, LPS);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("vred_unit: LANES must be a power of two of at least 2");
   end
   if (LW < 2) begin : g_bad_lw
      $error("vred_unit: LW must be at least 2");
   end
   if (LPS < 1) begin : g_bad_lps
      $error("vred_unit: LPS must be at least 1");
   end

   logic [LANES*NW-1:0] leaves;
   logic [NW-1:0]       root;

   vred_front #(.LANES(LANES), .LW(LW), .SW(SW), .IW(IW)) u_front (
      .dot_sel (in_op == VR_DOT),
      .vec_a   (in_a),
      .vec_b   (in_b),
      .leaves  (leaves)
   );

   vred_tree #(.LANES(LANES), .LW(LW), .SW(SW), .IW(IW), .LPS(LPS)) u_tree (
      .clk    (clk),
      .leaves (leaves),
      .root   (root)
   );

   // Side band: valid and operation code ride with the tree stages.
   logic     v_pipe  [NREG];
   vred_op_e op_pipe [NREG];

   for (genvar s = 0; s < NREG; s++) begin : g_side
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) v_pipe[s] <= 1'b0;
            else        v_pipe[s] <= in_valid;
            op_pipe[s] <= vred_op_e'(in_op);
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) v_pipe[s] <= 1'b0;
            else        v_pipe[s] <= v_pipe[s-1];
            op_pipe[s] <= op_pipe[s-1];
         end
      end
   end

   logic                 is_min;
   logic [SW-1:0]        root_sum;
   logic [LW-1:0]        root_min;
   logic [IW-1:0]        root_idx;

   assign root_sum = root[NW-1 -: SW];
   assign root_min = root[IW +: LW];
   assign root_idx = root[IW-1:0];
   assign is_min   = op_pipe[NREG-1] == VR_MIN;

   assign out_valid  = v_pipe[NREG-1];
   assign out_result = is_min ? {{(SW-LW){root_min[LW-1]}}, root_min} : root_sum;
   assign out_idx    = is_min ? root_idx : '0;

endmodule

// File: rtl/vred_chk.sv
// Port-level checker for vred_unit, attached through bind.
module vred_chk #(
   parameter int LANES = 16,
   parameter int LW    = 16,
   parameter int LPS   = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          in_valid,
   input logic [1:0]                    in_op,
   input logic                          out_valid,
   input logic [2*LW+$clog2(LANES)-1:0] out_result,
   input logic [$clog2(LANES)-1:0]      out_idx
);
   localparam int LOG  = $clog2(LANES);
   localparam int RW   = 2 * LW + LOG;
   localparam int NREG = vred_pkg::reg_stages(LOG, LPS);

   logic       vsh  [NREG];
   logic [1:0] opsh [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NREG; s++) begin
            vsh[s]  <= 1'b0;
            opsh[s] <= 2'd0;
         end
      end else begin
         vsh[0]  <= in_valid;
         opsh[0] <= in_op;
         for (int s = 1; s < NREG; s++) begin
            vsh[s]  <= vsh[s-1];
            opsh[s] <= opsh[s-1];
         end
      end
   end

   // R6: a strobe leaves after the fixed number of stages.
   a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vsh[NREG-1]);

   // R5: no lane number for the non-minimum operations.
   a_r5_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (vsh[NREG-1] && opsh[NREG-1] != 2'd2) |-> out_idx == '0);

   // R3: a minimum is always a sign-extended lane value.
   a_r3_min_range: assert property (@(posedge clk) disable iff (!rst_n)
      (vsh[NREG-1] && opsh[NREG-1] == 2'd2) |->
         (out_result[RW-1:LW-1] == '0 || &out_result[RW-1:LW-1]));

   // R1: a plain sum never needs more than LW+LOG signed bits.
   a_r1_sum_range: assert property (@(posedge clk) disable iff (!rst_n)
      (vsh[NREG-1] && (opsh[NREG-1] == 2'd0 || opsh[NREG-1] == 2'd3)) |->
         (out_result[RW-1:LW+LOG-1] == '0 || &out_result[RW-1:LW+LOG-1]));

endmodule

bind vred_unit vred_chk #(.LANES(LANES), .LW(LW), .LPS(LPS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_op      (in_op),
   .out_valid  (out_valid),
   .out_result (out_result),
   .out_idx    (out_idx)
);

// File: tb/vred_unit_tb_top.sv
module vred_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 16;
   localparam int LW         = 16;
   localparam int VW         = LANES * LW;
   localparam int RW         = 36;
   localparam int IW         = 4;
   localparam int LAT        = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [1:0]    in_op;
   logic [VW-1:0] in_a;
   logic [VW-1:0] in_b;
   logic          out_valid;
   logic [RW-1:0] out_result;
   logic [IW-1:0] out_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   vred_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_op      (in_op),
      .in_a       (in_a),
      .in_b       (in_b),
      .out_valid  (out_valid),
      .out_result (out_result),
      .out_idx    (out_idx)
   );

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   // Expected-result slots, slot 0 newest.
   logic   s_v   [LAT];
   logic   [1:0] s_op [LAT];
   longint s_res [LAT];
   int     s_idx [LAT];
   string  s_tag [LAT];

   function automatic longint lane_of(input logic [VW-1:0] v, input int i);
      logic signed [LW-1:0] x;
      x = v[i*LW +: LW];
      return longint'(x);
   endfunction

   function automatic longint f_res(input logic [1:0] op, input logic [VW-1:0] a,
                                    input logic [VW-1:0] b);
      longint acc;
      longint mn;
      acc = 0;
      mn  = lane_of(a, 0);
      for (int i = 0; i < LANES; i++) begin
         if (op == 2'd1) acc += lane_of(a, i) * lane_of(b, i);
         else            acc += lane_of(a, i);
         if (lane_of(a, i) < mn) mn = lane_of(a, i);
      end
      return (op == 2'd2) ? mn : acc;
   endfunction

   function automatic int f_idx(input logic [1:0] op, input logic [VW-1:0] a);
      int k;
      k = 0;
      if (op != 2'd2) return 0;
      for (int i = 1; i < LANES; i++)
         if (lane_of(a, i) < lane_of(a, k)) k = i;
      return k;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // One cycle: compare outputs against the entry issued LAT cycles ago,
   // then drive the next request.
   task automatic step(input logic v, input logic [1:0] op, input logic [VW-1:0] a,
                       input logic [VW-1:0] b, input string tag);
      logic signed [RW-1:0] act;
      @(negedge clk);
      act = out_result;
      check(out_valid === s_v[LAT-1], {"R6/", s_tag[LAT-1]}, "out_valid",
            longint'(out_valid), longint'(s_v[LAT-1]));
      if (s_v[LAT-1]) begin
         check(longint'(act) == s_res[LAT-1], s_tag[LAT-1], "out_result",
               longint'(act), s_res[LAT-1]);
         check(int'(out_idx) == s_idx[LAT-1],
               (s_op[LAT-1] == 2'd2) ? s_tag[LAT-1] : "R5", "out_idx",
               longint'(out_idx), longint'(s_idx[LAT-1]));
      end
      for (int s = LAT-1; s > 0; s--) begin
         s_v[s] = s_v[s-1]; s_op[s] = s_op[s-1];
         s_res[s] = s_res[s-1]; s_idx[s] = s_idx[s-1]; s_tag[s] = s_tag[s-1];
      end
      s_v[0]   = v;
      s_op[0]  = op;
      s_res[0] = f_res(op, a, b);
      s_idx[0] = f_idx(op, a);
      s_tag[0] = tag;
      in_valid = v;
      in_op    = op;
      in_a     = a;
      in_b     = b;
   endtask

   function automatic logic [VW-1:0] fill(input logic [LW-1:0] x);
      logic [VW-1:0] v;
      for (int i = 0; i < LANES; i++) v[i*LW +: LW] = x;
      return v;
   endfunction

   function automatic logic [VW-1:0] rnd_vec(input bit narrow);
      logic [VW-1:0] v;
      for (int i = 0; i < LANES; i++) begin
         if (narrow) v[i*LW +: LW] = LW'($urandom % 4) - LW'(2);
         else        v[i*LW +: LW] = LW'($urandom);
      end
      return v;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] va;
      logic [VW-1:0] vb;
      void'($urandom(32'h1F2E3D4C));
      for (int s = 0; s < LAT; s++) begin
         s_v[s] = 1'b0; s_op[s] = 2'd0; s_res[s] = 0; s_idx[s] = 0; s_tag[s] = "R8";
      end
      rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0; in_a = '0; in_b = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      check(out_valid === 1'b0, "R8", "out_valid in reset", longint'(out_valid), 0);
      rst_n = 1'b1;
      repeat (4) step(1'b0, 2'd0, '0, '0, "R8");

      // Directed corner cases
      step(1'b1, 2'd0, fill(16'h7FFF), fill(16'h1234), "R1");
      step(1'b1, 2'd0, fill(16'h8000), '0, "R1");
      step(1'b1, 2'd1, fill(16'h8000), fill(16'h8000), "R2");
      step(1'b1, 2'd1, fill(16'h7FFF), fill(16'h8000), "R2");
      step(1'b1, 2'd2, fill(16'h0005), '0, "R4");
      va = fill(16'h0100); va[15*LW +: LW] = 16'hFF00;
      step(1'b1, 2'd2, va, '0, "R3");
      va = fill(16'h0010); va[5*LW +: LW] = 16'hFFF0; va[9*LW +: LW] = 16'hFFF0;
      step(1'b1, 2'd2, va, fill(16'hFFFF), "R4");
      va = rnd_vec(1'b0);
      step(1'b1, 2'd0, va, '0, "R9");
      step(1'b1, 2'd0, va, rnd_vec(1'b0), "R9");
      step(1'b1, 2'd2, va, '0, "R9");
      step(1'b1, 2'd2, va, rnd_vec(1'b0), "R9");
      step(1'b1, 2'd3, fill(16'hFFFF), fill(16'h7FFF), "R7");
      step(1'b0, 2'd1, fill(16'h7FFF), fill(16'h7FFF), "R8");

      // Constrained random traffic
      for (int t = 0; t < 600; t++) begin
         logic [1:0] op;
         logic       v;
         string      tg;
         op = 2'($urandom % 4);
         v  = ($urandom % 5) != 0;
         va = rnd_vec(($urandom % 2) == 0);
         vb = rnd_vec(1'b0);
         case (op)
            2'd0:    tg = "R1";
            2'd1:    tg = "R2";
            2'd2:    tg = "R3";
            default: tg = "R7";
         endcase
         if (!v) tg = "R8";
         step(v, op, va, vb, tg);
      end
      repeat (LAT + 1) step(1'b0, 2'd0, '0, '0, "R8");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule